// File: doc/BRIEF.md
# Role-Windowed Register File

This block stores the registers of a processor whose register names are not flat. The storage is a pool of 64 windows, each with 16 registers of 32 bits, and the windows do not overlap. A task reaches at most seven of them at a time. Each of the seven is named by its role: a global window, the window of the calling procedure, the window of the running procedure, a bookkeeping map window, the head and tail windows of a stack or queue, and a per-task object window. Seven window-id pointers hold the current role-to-window binding. Each logical register number is translated into a physical window and a register index through those pointers.

Two read ports and one write port take 7-bit logical register numbers. A pointer load port rebinds one role to another physical window per cycle. This is how a call, a return or a task switch changes which windows are visible. When two roles point at the same window, they name the same storage. That is the only way data is shared, because a window never overlaps with another. Spilling to memory, instruction decode and protection are handled elsewhere.

Top module: `win_regfile`

## Requirements
- R1: The storage holds 64 windows of 16 registers of 32 bits. A register lives at physical address window_id*16 + index, so windows with different ids never share a register.
- R2: In a 7-bit logical register number, bits [6:4] pick the role and bits [3:0] pick the register inside the window. The role codes are: 0 global, 1 caller, 2 callee, 3 map, 4 queue head, 5 queue tail, 6 object.
- R3: A read through role code 7 returns zero on that port.
- R4: A write through role code 7 changes no register.
- R5: Reads are combinational. A write is stored at the rising clock edge and is visible from the next cycle. A read of the register being written in the same cycle returns the old value.
- R6: A pointer load with selector 0 to 6 rebinds that role to the given 6-bit window id from the next cycle on. A write in the same cycle as the load still uses the old binding.
- R7: A pointer load with selector 7 changes no binding.
- R8: While reset_n is low at a clock edge, each role's pointer is set to its own role code: global to window 0, caller to 1, and so on up to object to 6.
- R9: Two roles bound to the same window id read and write the same registers.
- R10: The two read ports work independently and can read different logical registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the role pointers |
| rd_a_reg | input | 7 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_reg | input | 7 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 7 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| ptr_ld | input | 1 | Pointer load enable |
| ptr_sel | input | 3 | Role code of the pointer to load |
| ptr_id | input | 6 | New window id for that role |

## Verification
The write-then-read property assumes no pointer load in the write cycle, because a load in that cycle lets the read resolve through a different binding. The property is therefore gated on the absence of a load. The properties also take the inputs to be known two-state values at every clock edge. The bench drives every input at the falling edge from defined values, and it includes cycles that load a pointer and write at the same time, so that the binding order is exercised without breaking these assumptions. The register contents are never reset, so the reference model compares a read only when it has seen that physical register written.

// File: rtl/wrf_pkg.sv
// Package: shared role codes and fixed field widths of the role-windowed
// register file. Assumes the role field of a logical register is 3 bits.
package wrf_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_ROLES = 7;

    typedef enum logic [SEL_W-1:0] {
        ROLE_GLOBAL = 3'd0,
        ROLE_CALLER = 3'd1,
        ROLE_CALLEE = 3'd2,
        ROLE_MAP    = 3'd3,
        ROLE_QHEAD  = 3'd4,
        ROLE_QTAIL  = 3'd5,
        ROLE_OBJECT = 3'd6,
        ROLE_NONE   = 3'd7
    } role_e;
endpackage

// File: rtl/wrf_ptr_table.sv
// Module: holds one window-id pointer per role. Each pointer resets to its
// own role code and is reloaded through the single load port. A load whose
// selector matches no role (the reserved code) is ignored. Assumes the
// inputs are synchronous to clk.
module wrf_ptr_table
    import wrf_pkg::*;
#(
    parameter int WID_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld,
    input  logic [SEL_W-1:0]           sel,
    input  logic [WID_W-1:0]           id,
    output logic [NUM_ROLES*WID_W-1:0] ptrs
);
    genvar r;
    generate
        for (r = 0; r < NUM_ROLES; r++) begin : g_role
            logic [WID_W-1:0] ptr_q;

            // Reset this role's pointer to its own code, or reload it on a matching load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q <= WID_W'(r);
                end else if (ld && (sel == SEL_W'(r))) begin
                    ptr_q <= id;
                end
            end

            assign ptrs[r*WID_W +: WID_W] = ptr_q;
        end
    endgenerate
endmodule

// File: rtl/wrf_addr_map.sv
// Module: translates one logical register number into a physical address.
// The role field selects a pointer, and the pointer is concatenated with the
// register index. The reserved role code yields valid = 0. Assumes the
// number of registers per window is a power of two.
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int WID_W  = 6,
    parameter int IDX_W  = 4,
    localparam int LREG_W = SEL_W + IDX_W,
    localparam int ADDR_W = WID_W + IDX_W
) (
    input  logic [LREG_W-1:0]          lreg,
    input  logic [NUM_ROLES*WID_W-1:0] ptrs,
    output logic [ADDR_W-1:0]          paddr,
    output logic                       valid
);
    logic [SEL_W-1:0] role;
    logic [IDX_W-1:0] idx;
    logic [WID_W-1:0] win;

    assign role = lreg[LREG_W-1 -: SEL_W];
    assign idx  = lreg[IDX_W-1:0];

    // Pick the window id of the addressed role; the reserved code maps to nothing.
    always_comb begin
        valid = (role != ROLE_NONE);
        win   = '0;
        for (int r = 0; r < NUM_ROLES; r++) begin
            if (role == SEL_W'(r)) begin
                win = ptrs[r*WID_W +: WID_W];
            end
        end
    end

    assign paddr = {win, idx};
endmodule

// File: rtl/wrf_store.sv
// Module: the physical register array. It has two combinational read ports
// and one write port that is stored at the rising edge. The contents are
// not reset. Assumes at most one write per cycle.
module wrf_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write data at the addressed register.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/win_regfile.sv
// Module: top of the role-windowed register file. It maps the logical
// numbers of two read ports and one write port through the role pointers
// into a pool of non-overlapping windows. Assumes a single clock and a
// synchronous active-low reset that clears only the pointers.
module win_regfile
    import wrf_pkg::*;
#(
    parameter int NUM_WIN  = 64,
    parameter int WIN_REGS = 16,
    parameter int DATA_W   = 32,
    localparam int WID_W  = $clog2(NUM_WIN),
    localparam int IDX_W  = $clog2(WIN_REGS),
    localparam int LREG_W = SEL_W + IDX_W,
    localparam int ADDR_W = WID_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LREG_W-1:0] rd_a_reg,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [LREG_W-1:0] rd_b_reg,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [LREG_W-1:0] wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ptr_ld,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [WID_W-1:0]  ptr_id
);
    localparam int NPORT = 3;   // read A, read B, write

    logic [NUM_ROLES*WID_W-1:0] role_ptrs;
    logic [LREG_W-1:0]          port_lreg  [NPORT];
    logic [ADDR_W-1:0]          port_paddr [NPORT];
    logic                       port_valid [NPORT];
    logic [DATA_W-1:0]          raw_a, raw_b;

    wrf_ptr_table #(.WID_W(WID_W)) u_ptrs (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (ptr_ld),
        .sel  (ptr_sel),
        .id   (ptr_id),
        .ptrs (role_ptrs)
    );

    assign port_lreg[0] = rd_a_reg;
    assign port_lreg[1] = rd_b_reg;
    assign port_lreg[2] = wr_reg;

    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_map
            wrf_addr_map #(.WID_W(WID_W), .IDX_W(IDX_W)) u_map (
                .lreg (port_lreg[p]),
                .ptrs (role_ptrs),
                .paddr(port_paddr[p]),
                .valid(port_valid[p])
            );
        end
    endgenerate

    wrf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .we     (wr_en & port_valid[2]),
        .waddr  (port_paddr[2]),
        .wdata  (wr_data),
        .raddr_a(port_paddr[0]),
        .rdata_a(raw_a),
        .raddr_b(port_paddr[1]),
        .rdata_b(raw_b)
    );

    // Force reads through the reserved role code to zero.
    always_comb begin
        rd_a_data = port_valid[0] ? raw_a : '0;
        rd_b_data = port_valid[1] ? raw_b : '0;
    end
endmodule

// File: rtl/wrf_checker.sv
// Module: property checker for win_regfile, attached by bind. It observes
// the ports and the role pointer vector. Assumes known inputs at clock edges.
module wrf_checker
    import wrf_pkg::*;
#(
    parameter int WID_W  = 6,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    localparam int LREG_W = SEL_W + IDX_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [LREG_W-1:0]          rd_a_reg,
    input logic [DATA_W-1:0]          rd_a_data,
    input logic                       wr_en,
    input logic [LREG_W-1:0]          wr_reg,
    input logic [DATA_W-1:0]          wr_data,
    input logic                       ptr_ld,
    input logic [SEL_W-1:0]           ptr_sel,
    input logic [WID_W-1:0]           ptr_id,
    input logic [NUM_ROLES*WID_W-1:0] role_ptrs
);
    logic [NUM_ROLES*WID_W-1:0] reset_pattern;
    logic                       ld_q;
    logic [SEL_W-1:0]           sel_q;
    logic [WID_W-1:0]           id_q;
    logic [WID_W-1:0]           loaded_ptr;

    // Build the pointer vector expected right after reset.
    always_comb begin
        for (int r = 0; r < NUM_ROLES; r++) begin
            reset_pattern[r*WID_W +: WID_W] = WID_W'(r);
        end
    end

    // Remember the last cycle's load request; cleared during reset.
    always_ff @(posedge clk) begin
        ld_q  <= rst_n & ptr_ld;
        sel_q <= ptr_sel;
        id_q  <= ptr_id;
    end

    // Extract the pointer named by the remembered selector.
    always_comb begin
        loaded_ptr = '0;
        for (int r = 0; r < NUM_ROLES; r++) begin
            if (sel_q == SEL_W'(r)) loaded_ptr = role_ptrs[r*WID_W +: WID_W];
        end
    end

    // R3
    zero_on_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_reg[LREG_W-1 -: SEL_W] == ROLE_NONE) |-> (rd_a_data == '0));

    // R5
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_reg[LREG_W-1 -: SEL_W] != ROLE_NONE) && !ptr_ld)
        ##1 (rd_a_reg == $past(wr_reg)) |-> (rd_a_data == $past(wr_data)));

    // R6
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q && (sel_q != ROLE_NONE)) |-> (loaded_ptr == id_q));

    // R7
    reserved_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_ld && (ptr_sel == ROLE_NONE)) |=> $stable(role_ptrs));

    // R8
    reset_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (role_ptrs == reset_pattern));
endmodule

bind win_regfile wrf_checker #(.WID_W(WID_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_wrf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_reg (rd_a_reg),
    .rd_a_data(rd_a_data),
    .wr_en    (wr_en),
    .wr_reg   (wr_reg),
    .wr_data  (wr_data),
    .ptr_ld   (ptr_ld),
    .ptr_sel  (ptr_sel),
    .ptr_id   (ptr_id),
    .role_ptrs(role_ptrs)
);

// File: tb/test_win_regfile.sv
// Bench: behavioural reference model (pointer list plus associative storage)
// compared against both read ports on every clock.
module test_win_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  rd_a_reg, rd_b_reg, wr_reg;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, ptr_ld;
    logic [2:0]  ptr_sel;
    logic [5:0]  ptr_id;

    int          checks = 0;
    int          fails  = 0;
    int          m_ptr [7];
    logic [31:0] m_mem [int];

    always #4 clk = ~clk;   // 125 MHz

    win_regfile i_win_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_reg(rd_a_reg), .rd_a_data(rd_a_data),
        .rd_b_reg(rd_b_reg), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
        .ptr_ld(ptr_ld), .ptr_sel(ptr_sel), .ptr_id(ptr_id)
    );

    function automatic int paddr(input logic [6:0] lr);
        return m_ptr[lr[6:4]] * 16 + int'(lr[3:0]);
    endfunction

    task automatic check_port(input string tag, input string pname,
                              input logic [6:0] lr, input logic [31:0] act);
        logic [31:0] exp;
        if (lr[6:4] == 3'd7) exp = 32'h0;
        else if (m_mem.exists(paddr(lr))) exp = m_mem[paddr(lr)];
        else return;
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port %s reg %h: actual %h expected %h", tag, pname, lr, act, exp);
        end
    endtask

    // One clock: compare outputs for the current inputs, then advance the model.
    task automatic cycle(input string tag);
        #1;
        if (rst_n) begin
            check_port(tag, "A", rd_a_reg, rd_a_data);
            check_port(tag, "B", rd_b_reg, rd_b_data);
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int r = 0; r < 7; r++) m_ptr[r] = r;
        end else begin
            if (wr_en && wr_reg[6:4] != 3'd7) m_mem[paddr(wr_reg)] = wr_data;
            if (ptr_ld && ptr_sel != 3'd7) m_ptr[ptr_sel] = int'(ptr_id);
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic [6:0] ra, input logic [6:0] rb,
                         input logic we, input logic [6:0] wr, input logic [31:0] wd,
                         input logic ld, input logic [2:0] ps, input logic [5:0] pid,
                         input string tag);
        rd_a_reg = ra; rd_b_reg = rb;
        wr_en = we; wr_reg = wr; wr_data = wd;
        ptr_ld = ld; ptr_sel = ps; ptr_id = pid;
        cycle(tag);
    endtask

    task automatic idle_read(input logic [6:0] ra, input logic [6:0] rb, input string tag);
        drive(ra, rb, 1'b0, 7'h0, 32'h0, 1'b0, 3'd0, 6'd0, tag);
    endtask

    // Read every register of every role through both ports.
    task automatic sweep(input string tag);
        for (int r = 0; r < 7; r++)
            for (int k = 0; k < 16; k++)
                idle_read(7'((r << 4) | k), 7'(((6 - r) << 4) | (15 - k)), tag);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rd_a_reg = 7'h70; rd_b_reg = 7'h70;
        wr_en = 1'b0; wr_reg = '0; wr_data = '0;
        ptr_ld = 1'b0; ptr_sel = '0; ptr_id = '0;
        @(negedge clk);
        repeat (3) cycle("reset");
        rst_n = 1'b1;

        // R3: reserved role reads zero on both ports right after reset
        idle_read(7'h70, 7'h7f, "R3");

        // R1 R2 R8: fill every role window through the reset bindings
        for (int r = 0; r < 7; r++)
            for (int k = 0; k < 16; k++)
                drive(7'((r << 4) | k), 7'h75, 1'b1, 7'((r << 4) | k),
                      32'hA000_0000 | 32'(r << 8) | 32'(k), 1'b0, 3'd0, 6'd0, "R1");
        sweep("R2");

        // R8 R9: bind caller to window 0 and read the global data through it
        drive(7'h00, 7'h00, 1'b0, 7'h0, 32'h0, 1'b1, 3'd1, 6'd0, "R8");
        for (int k = 0; k < 16; k++) idle_read(7'(16 | k), 7'(k), "R9");
        drive(7'h13, 7'h03, 1'b1, 7'h13, 32'h1234_5678, 1'b0, 3'd0, 6'd0, "R9");
        idle_read(7'h03, 7'h13, "R9");

        // R5: same-cycle read returns the old value, new value next cycle
        drive(7'h25, 7'h25, 1'b1, 7'h25, 32'hDEAD_BEEF, 1'b0, 3'd0, 6'd0, "R5");
        idle_read(7'h25, 7'h24, "R5");

        // R6: load and write together; the write uses the old binding
        drive(7'h44, 7'h44, 1'b1, 7'h44, 32'h0BAD_F00D, 1'b1, 3'd4, 6'd40, "R6");
        idle_read(7'h44, 7'h04, "R6");
        drive(7'h44, 7'h44, 1'b1, 7'h44, 32'h4444_0000, 1'b0, 3'd0, 6'd0, "R6");
        drive(7'h44, 7'h54, 1'b1, 7'h54, 32'h5555_0000, 1'b1, 3'd5, 6'd40, "R6");
        idle_read(7'h44, 7'h54, "R6");

        // R4: writes through the reserved code leave everything unchanged
        for (int k = 0; k < 16; k++)
            drive(7'h70, 7'h7f, 1'b1, 7'(7'h70 | k), 32'hFFFF_FFFF, 1'b0, 3'd0, 6'd0, "R4");
        sweep("R4");

        // R7: a load with the reserved selector binds nothing
        drive(7'h21, 7'h31, 1'b0, 7'h0, 32'h0, 1'b1, 3'd7, 6'd63, "R7");
        sweep("R7");

        // R10 and mixed traffic: random reads, writes and loads
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] ra, rb, wr;
            ra = 7'($urandom_range(0, 127));
            rb = 7'($urandom_range(0, 127));
            wr = 7'($urandom_range(0, 127));
            drive(ra, rb, 1'($urandom_range(0, 3) != 0), wr, $urandom(),
                  1'($urandom_range(0, 5) == 0), 3'($urandom_range(0, 7)),
                  6'($urandom_range(0, 11)), "R10");
        end
        sweep("R10");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule